// File: doc/BRIEF.md
# Debounced Serial Operand Loader

This block assembles two 3-bit operands from a single data switch and one push button. The raw button passes through a two-flop synchronizer and then a debouncer. The debouncer accepts a new button level only after that level has held steadily for a set number of clock cycles. Each clean press, meaning a rising edge of the debounced level, moves the current value of the data switch into a 6-bit serial-in, parallel-out register.

A separate trigger switch commits the register contents. On the trigger's rising edge, the upper three bits go to operand A and the lower three bits go to operand B. A one-cycle `valid` strobe tells the downstream arithmetic unit that a fresh operand pair is ready. Every input is asynchronous to `clk`, so all three pass through two-flop synchronizers. The button is used only as data and never as a clock.

Top module: `serial_operand_loader`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `op_a`, `op_b` and `valid` are zero. Reset also empties the shift register, so a commit made before any press yields A = 0 and B = 0.
- R2: The debounced button level follows a new raw level only after the synchronized raw button has differed from it for DELAY consecutive clock cycles. A press held for exactly DELAY cycles is accepted.
- R3: If the raw button returns to the accepted level before DELAY cycles have passed, the stability count restarts. A press of DELAY-1 cycles or less, or a burst of short glitches, shifts nothing.
- R4: Each accepted press shifts exactly one bit. Holding the button down or releasing it shifts nothing more.
- R5: Bit order: the last six accepted bits are kept. The oldest of them lands in `op_a[2]` and the newest in `op_b[0]`. After six shifts, A is register bits [5:3] and B is bits [2:0].
- R6: A rising edge of `go` copies register bits [5:3] to `op_a` and bits [2:0] to `op_b`, and raises `valid` for exactly one cycle.
- R7: Holding `go` high gives no further `valid` pulses. `op_a` and `op_b` change only in the cycle where `valid` is high, so presses made without a commit leave them unchanged.
- R8: All inputs pass through two synchronizer flops. A `go` rise driven between clock edges shows on `valid` at the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Serial data switch, asynchronous |
| btn | input | 1 | Raw push button, asynchronous, may bounce |
| go | input | 1 | Commit trigger switch, asynchronous |
| op_a | output | 3 | Committed operand A |
| op_b | output | 3 | Committed operand B |
| valid | output | 1 | One-cycle strobe when a new pair is committed |

## Verification
The checker watches several rules on every cycle:
- the debounced level changes only after the stability counter reaches its limit and only to the synchronized raw value;
- the register moves only on a clean edge, and then takes in the synchronized data bit;
- `valid` never lasts two cycles;
- the outputs change only with `valid` and equal the register contents of the cycle before.

Other behaviour needs whole scenarios, which the bench provides. These are the end-to-end bit order across six presses, the exact DELAY versus DELAY-1 acceptance boundary, the rejection of glitch bursts, the three-edge latency from `go` to `valid`, and the clearing of partly entered bits by reset.

// File: rtl/opl_pkg.sv
package opl_pkg;
    localparam int OP_W = 3;
    localparam int SR_W = 2 * OP_W;

    typedef logic [OP_W-1:0] operand_t;
    typedef logic [SR_W-1:0] shreg_t;

    typedef struct packed {
        operand_t a;
        operand_t b;
    } operand_pair_t;

    // oldest bits form A, newest bits form B
    function automatic operand_pair_t split_shreg(input shreg_t r);
        operand_pair_t p;
        p.a = r[SR_W-1:OP_W];
        p.b = r[OP_W-1:0];
        return p;
    endfunction
endpackage

// File: rtl/opl_sync2.sv
module opl_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/opl_debounce.sv
module opl_debounce #(
    parameter int DELAY = 16,
    parameter int CNT_W = $clog2(DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    output logic             clean,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            clean <= 1'b0;
            cnt   <= '0;
        end else if (raw == clean) begin
            cnt <= '0;
        end else if (cnt == LIMIT) begin
            clean <= raw;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/opl_shifter.sv
module opl_shifter
    import opl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clean,
    input  logic   si_s,
    output logic   shift_en,
    output shreg_t sr
);
    logic clean_d;

    assign shift_en = clean & ~clean_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            clean_d <= 1'b0;
            sr      <= '0;
        end else begin
            clean_d <= clean;
            if (shift_en)
                sr <= {sr[SR_W-2:0], si_s};
        end
    end
endmodule

// File: rtl/opl_commit.sv
module opl_commit
    import opl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go_s,
    input  shreg_t        sr,
    output operand_pair_t pair,
    output logic          valid
);
    logic go_d;
    logic go_rise;

    assign go_rise = go_s & ~go_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_d  <= 1'b0;
            pair  <= '0;
            valid <= 1'b0;
        end else begin
            go_d  <= go_s;
            valid <= go_rise;
            if (go_rise)
                pair <= split_shreg(sr);
        end
    end
endmodule

// File: rtl/serial_operand_loader.sv
module serial_operand_loader
    import opl_pkg::*;
#(
    parameter int DELAY = 16,
    localparam int CNT_W = $clog2(DELAY + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        si,
    input  logic        btn,
    input  logic        go,
    output logic [2:0]  op_a,
    output logic [2:0]  op_b,
    output logic        valid
);
    logic [2:0]       raw_in;
    logic [2:0]       sync_out;
    logic             si_s;
    logic             btn_s;
    logic             go_s;
    logic             btn_clean;
    logic [CNT_W-1:0] db_cnt;
    logic             shift_en;
    shreg_t           sr;
    operand_pair_t    pair;

    assign raw_in = {go, btn, si};

    opl_sync2 #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    assign si_s  = sync_out[0];
    assign btn_s = sync_out[1];
    assign go_s  = sync_out[2];

    opl_debounce #(.DELAY(DELAY), .CNT_W(CNT_W)) u_db (
        .clk   (clk),
        .rst   (rst),
        .raw   (btn_s),
        .clean (btn_clean),
        .cnt   (db_cnt)
    );

    opl_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clean    (btn_clean),
        .si_s     (si_s),
        .shift_en (shift_en),
        .sr       (sr)
    );

    opl_commit u_commit (
        .clk   (clk),
        .rst   (rst),
        .go_s  (go_s),
        .sr    (sr),
        .pair  (pair),
        .valid (valid)
    );

    assign op_a = pair.a;
    assign op_b = pair.b;
endmodule

// File: rtl/serial_operand_loader_chk.sv
module serial_operand_loader_chk
    import opl_pkg::*;
#(
    parameter int DELAY = 16,
    parameter int CNT_W = $clog2(DELAY + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             btn_s,
    input logic             si_s,
    input logic             btn_clean,
    input logic [CNT_W-1:0] db_cnt,
    input logic             shift_en,
    input shreg_t           sr,
    input logic [2:0]       op_a,
    input logic [2:0]       op_b,
    input logic             valid
);
    // R2: accepted level changes only at the end of a full stable window
    p_clean_after_window_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(btn_clean) |-> ($past(db_cnt) == CNT_W'(DELAY - 1) && btn_clean == $past(btn_s)));

    // R3: count restarts once the raw level matches the accepted one again
    p_count_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (btn_s == btn_clean) |=> (db_cnt == '0));

    // R4: one shift per clean edge, taking the synchronized data bit
    p_shift_bit_r4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (sr[0] == $past(si_s) && sr[SR_W-1:1] == $past(sr[SR_W-2:0])));

    p_no_shift_r4: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr));

    // R6: valid lasts a single cycle, outputs carry the prior register halves
    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_commit_value_r6: assert property (@(posedge clk) disable iff (rst)
        valid |-> (op_a == $past(sr[SR_W-1:OP_W]) && op_b == $past(sr[OP_W-1:0])));

    // R7: operands hold whenever no commit takes place
    p_hold_outputs_r7: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(op_a) && $stable(op_b)));
endmodule

bind serial_operand_loader serial_operand_loader_chk #(.DELAY(DELAY), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .btn_s     (btn_s),
    .si_s      (si_s),
    .btn_clean (btn_clean),
    .db_cnt    (db_cnt),
    .shift_en  (shift_en),
    .sr        (sr),
    .op_a      (op_a),
    .op_b      (op_b),
    .valid     (valid)
);

// File: tb/serial_operand_loader_bench.sv
module serial_operand_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY      = 4;
    localparam int NVEC       = 6;
    // {six entered bits, oldest first in bit 5; expected A; expected B}
    localparam logic [11:0] VEC [0:NVEC-1] = '{
        {6'b101011, 3'b101, 3'b011},
        {6'b000000, 3'b000, 3'b000},
        {6'b111111, 3'b111, 3'b111},
        {6'b100001, 3'b100, 3'b001},
        {6'b011100, 3'b011, 3'b100},
        {6'b010101, 3'b010, 3'b101}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic si  = 1'b0;
    logic btn = 1'b0;
    logic go  = 1'b0;
    logic [2:0] op_a;
    logic [2:0] op_b;
    logic       valid;

    int checks = 0;
    int errors = 0;
    int pulses;
    logic [2:0] got_a;
    logic [2:0] got_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_operand_loader #(.DELAY(DELAY)) u_serial_operand_loader (
        .clk   (clk),
        .rst   (rst),
        .si    (si),
        .btn   (btn),
        .go    (go),
        .op_a  (op_a),
        .op_b  (op_b),
        .valid (valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // press of a given width in clock cycles, then a long release
    task automatic press(input logic b, input int width);
        @(negedge clk);
        si = b;
        idle(4);
        btn = 1'b1;
        idle(width);
        btn = 1'b0;
        idle(DELAY + 6);
    endtask

    task automatic enter6(input logic [5:0] bits);
        for (int i = 5; i >= 0; i--) press(bits[i], DELAY + 3);
    endtask

    // raise go, count valid pulses while it stays high, then release
    task automatic commit();
        @(negedge clk);
        go = 1'b1;
        pulses = 0;
        for (int i = 0; i < 14; i++) begin
            @(posedge clk);
            #1;
            if (valid) begin
                pulses++;
                got_a = op_a;
                got_b = op_b;
            end
        end
        @(negedge clk);
        go = 1'b0;
        idle(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        check("R1 reset op_a", {5'd0, op_a}, 8'd0);
        check("R1 reset op_b", {5'd0, op_b}, 8'd0);
        check("R1 reset valid", {7'd0, valid}, 8'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 first cycle after reset", {1'b0, valid, op_a, op_b}, 8'd0);
        idle(4);

        // R5 R6: table of operand patterns
        for (int v = 0; v < NVEC; v++) begin
            enter6(VEC[v][11:6]);
            commit();
            check("R6 one valid pulse", 8'(pulses), 8'd1);
            check("R5 operand A", {5'd0, got_a}, {5'd0, VEC[v][5:3]});
            check("R5 operand B", {5'd0, got_b}, {5'd0, VEC[v][2:0]});
        end

        // R7: presses without commit leave outputs alone, go held gives one pulse
        enter6(6'b110001);
        press(1'b0, DELAY + 3);
        check("R7 hold A without commit", {5'd0, op_a}, 8'h2);
        check("R7 hold B without commit", {5'd0, op_b}, 8'h5);
        commit();
        check("R7 single pulse with go held", 8'(pulses), 8'd1);
        check("R5 seventh bit drops oldest A", {5'd0, got_a}, 8'h4);
        check("R5 seventh bit drops oldest B", {5'd0, got_b}, 8'h2);

        // R2 R3: exact window boundary
        enter6(6'b000000);
        press(1'b1, DELAY - 1);
        commit();
        check("R3 press of DELAY-1 ignored", {2'd0, got_a, got_b}, 8'h00);
        press(1'b1, DELAY);
        commit();
        check("R2 press of DELAY accepted", {2'd0, got_a, got_b}, 8'h01);

        // R3: bouncing input then one steady press gives exactly one shift
        @(negedge clk);
        si = 1'b1;
        idle(4);
        for (int g = 0; g < 5; g++) begin
            btn = 1'b1;
            idle(2);
            btn = 1'b0;
            idle(1);
        end
        btn = 1'b1;
        idle(DELAY + 3);
        btn = 1'b0;
        idle(DELAY + 6);
        commit();
        check("R3 bounce gives one shift", {2'd0, got_a, got_b}, 8'h03);

        // R4: long hold shifts only once
        press(1'b1, 10 * DELAY);
        commit();
        check("R4 long hold one shift", {2'd0, got_a, got_b}, 8'h07);

        // R8: latency of go to valid
        @(negedge clk);
        go = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R8 no valid after two edges", {7'd0, valid}, 8'd0);
        @(posedge clk);
        #1;
        check("R8 valid at third edge", {7'd0, valid}, 8'd1);
        @(negedge clk);
        go = 1'b0;
        idle(6);

        // R1: reset mid-entry clears the register
        press(1'b1, DELAY + 3);
        press(1'b1, DELAY + 3);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        check("R1 reset clears outputs", {1'b0, valid, op_a, op_b}, 8'd0);
        rst = 1'b0;
        idle(3);
        commit();
        check("R1 commit after reset is zero", {2'd0, got_a, got_b}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule